// File: doc/BRIEF.md
# Pipeline Interlock and Stall Controller

This block is the interlock logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no bypass paths. Each cycle the datapath presents the instruction that sits in decode: its two source register numbers with use flags, its destination register and write enable, and whether it is a branch or a memory access. The execute stage also reports whether the branch it holds was resolved as taken. From these inputs the controller decides whether to freeze the program counter, freeze the fetch/decode register, insert a bubble into the decode/execute register, or replace the instruction that fetch is delivering with a no-op.

The controller keeps its own small shadow copy of the execute, memory and writeback stage fields that matter for hazards. It fills that copy from the decode inputs as instructions leave decode, and a bubble enters it as an empty slot. All of its outputs are combinational from the current decode inputs and the shadow stages. Read-after-write hazards are resolved by waiting. The register file writes in the first half of a cycle and reads in the second, so a consumer may leave decode in the same cycle its producer reaches writeback. The instruction behind a branch is squashed and fetched again after the branch has resolved in execute. There is a single memory port, so fetch yields to any load or store that is in the memory stage.

Top module: `stall_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it with no valid decode instruction, all four outputs (`pc_hold`, `ifid_hold`, `idex_bubble`, `if_flush`) are 0.
- R2: A valid decode instruction whose used source register equals the destination of a writing instruction now in execute or memory causes a data stall: `pc_hold`=1, `ifid_hold`=1, `idex_bubble`=1, `if_flush`=0.
- R3: A producer in writeback causes no stall. A consumer issued directly behind any producer, a load included, therefore waits exactly two cycles in decode.
- R4: Register 0, a destination with write enable low, and a source whose use flag is low never cause a stall.
- R5: When a load or store is in the memory stage and there is no data stall or taken branch, fetch is suppressed: `pc_hold`=1 and `if_flush`=1, while `ifid_hold`=0 and `idex_bubble`=0 so that decode still advances.
- R6: A data stall and a memory-port conflict in the same cycle give one combined hold: outputs 1,1,1,0 in the order `pc_hold`,`ifid_hold`,`idex_bubble`,`if_flush`.
- R7: A branch in decode that is not data-stalled leaves decode with `pc_hold`=1 and `if_flush`=1, so the following instruction is squashed and fetched again.
- R8: A branch in execute with `ex_taken`=1 gives `if_flush`=1 and `pc_hold`=0 (the target loads), even when the memory port is busy. With `ex_taken`=0 fetch proceeds normally.
- R9: `ex_taken` has no effect when execute holds no branch, whether that slot is empty or holds a non-branch instruction.
- R10: A branch in decode that is data-stalled is held like any stalled instruction (1,1,1,0) and is not flushed. It leaves decode with 1,0,0,1 once its producer reaches writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, empties the shadow stages |
| id_valid | input | 1 | Decode holds a real instruction |
| id_rs1 | input | 5 | First source register number |
| id_rs1_used | input | 1 | First source is actually read |
| id_rs2 | input | 5 | Second source register number |
| id_rs2_used | input | 1 | Second source is actually read |
| id_rd | input | 5 | Destination register number |
| id_we | input | 1 | Instruction writes its destination |
| id_mem | input | 1 | Instruction is a load or store |
| id_branch | input | 1 | Instruction is a conditional branch |
| ex_taken | input | 1 | Branch outcome from execute, 1 = taken |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load an empty control bundle into decode/execute |
| if_flush | output | 1 | Load a no-op into fetch/decode instead of the fetched word |

## Verification
On every cycle the assertions check how the outputs relate to each other and to the history of the decode inputs. A data hold always comes with a bubble and never with a flush. A writer one cycle ahead of a matching reader forces a bubble. A memory access issued two cycles earlier suppresses fetch. A branch that leaves decode squashes the slot behind it, and a taken resolution in execute flushes. Only the bench's scenarios can show the exact stall lengths: the two-cycle wait that ends when the producer reaches writeback, register 0 and unused sources being ignored, the combined structural and data hold, and `ex_taken` doing nothing without a branch in execute.

// File: rtl/stall_ctrl_pkg.sv
package stall_ctrl_pkg;

    localparam int REG_W    = 5;
    localparam int NSRC     = 2;
    localparam int STG_EX   = 0;
    localparam int STG_MEM  = 1;

    typedef logic [REG_W-1:0] reg_id_t;

    // Hazard-relevant fields of one in-flight instruction
    typedef struct packed {
        logic    valid;
        reg_id_t rd;
        logic    we;
        logic    mem;
    } slot_t;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
        logic if_flush;
    } ctl_t;

    // True when the slot will write register r (register 0 is never written)
    function automatic logic slot_writes(slot_t s, reg_id_t r);
        return s.valid && s.we && (s.rd != '0) && (s.rd == r);
    endfunction

endpackage

// File: rtl/stall_track.sv
module stall_track
    import stall_ctrl_pkg::*;
#(
    parameter int NTRACK = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t id_slot,
    input  logic  id_is_branch,
    input  logic  bubble,
    output slot_t stg [NTRACK],
    output logic  ex_branch
);

    slot_t q [NTRACK];
    logic  br_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q[0] <= '0;
            br_q <= 1'b0;
        end else begin
            q[0] <= bubble ? '0 : id_slot;
            br_q <= bubble ? 1'b0 : (id_slot.valid && id_is_branch);
        end
    end

    for (genvar i = 1; i < NTRACK; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst) q[i] <= '0;
            else     q[i] <= q[i-1];
        end
    end

    assign stg       = q;
    assign ex_branch = br_q;

endmodule

// File: rtl/stall_raw.sv
module stall_raw
    import stall_ctrl_pkg::*;
#(
    parameter int NTRACK = 2
) (
    input  logic    id_valid,
    input  reg_id_t src      [NSRC],
    input  logic    src_used [NSRC],
    input  slot_t   stg      [NTRACK],
    output logic    raw
);

    logic [NSRC*NTRACK-1:0] hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar k = 0; k < NTRACK; k++) begin : g_stg
            assign hit[s*NTRACK+k] = src_used[s] && slot_writes(stg[k], src[s]);
        end
    end

    assign raw = id_valid && (|hit);

endmodule

// File: rtl/stall_combine.sv
module stall_combine
    import stall_ctrl_pkg::*;
(
    input  logic raw,
    input  logic id_valid,
    input  logic id_branch,
    input  logic mem_busy,
    input  logic br_taken,
    output ctl_t ctl
);

    logic raw_eff;
    logic br_go;

    always_comb begin
        // a taken branch squashes decode anyway, so its hazards are moot
        raw_eff = raw && !br_taken;
        br_go   = id_valid && id_branch && !raw;

        ctl.ifid_hold   = raw_eff;
        ctl.idex_bubble = raw_eff;
        ctl.pc_hold     = raw_eff || br_go || (mem_busy && !br_taken);
        ctl.if_flush    = br_taken || (!raw_eff && (br_go || mem_busy));
    end

endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
    import stall_ctrl_pkg::*;
#(
    parameter bit SPLIT_RF = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_rs1,
    input  logic             id_rs1_used,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs2_used,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_we,
    input  logic             id_mem,
    input  logic             id_branch,
    input  logic             ex_taken,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             if_flush
);

    // With a split-cycle register file the writeback stage never blocks
    localparam int NTRACK = SPLIT_RF ? 2 : 3;

    slot_t   id_slot;
    slot_t   stg [NTRACK];
    logic    ex_branch;
    reg_id_t src      [NSRC];
    logic    src_used [NSRC];
    logic    raw;
    logic    mem_busy;
    logic    br_taken;
    ctl_t    ctl;

    assign id_slot     = '{valid: id_valid, rd: id_rd, we: id_we, mem: id_mem};
    assign src[0]      = id_rs1;
    assign src[1]      = id_rs2;
    assign src_used[0] = id_rs1_used;
    assign src_used[1] = id_rs2_used;

    stall_track #(.NTRACK(NTRACK)) u_track (
        .clk          (clk),
        .rst          (rst),
        .id_slot      (id_slot),
        .id_is_branch (id_branch),
        .bubble       (ctl.idex_bubble),
        .stg          (stg),
        .ex_branch    (ex_branch)
    );

    stall_raw #(.NTRACK(NTRACK)) u_raw (
        .id_valid (id_valid),
        .src      (src),
        .src_used (src_used),
        .stg      (stg),
        .raw      (raw)
    );

    assign mem_busy = stg[STG_MEM].valid && stg[STG_MEM].mem;
    assign br_taken = stg[STG_EX].valid && ex_branch && ex_taken;

    stall_combine u_comb (
        .raw       (raw),
        .id_valid  (id_valid),
        .id_branch (id_branch),
        .mem_busy  (mem_busy),
        .br_taken  (br_taken),
        .ctl       (ctl)
    );

    assign pc_hold     = ctl.pc_hold;
    assign ifid_hold   = ctl.ifid_hold;
    assign idex_bubble = ctl.idex_bubble;
    assign if_flush    = ctl.if_flush;

endmodule

// File: rtl/stall_ctrl_chk.sv
module stall_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       id_valid,
    input logic [4:0] id_rs1,
    input logic       id_rs1_used,
    input logic [4:0] id_rs2,
    input logic       id_rs2_used,
    input logic [4:0] id_rd,
    input logic       id_we,
    input logic       id_mem,
    input logic       id_branch,
    input logic       ex_taken,
    input logic       pc_hold,
    input logic       ifid_hold,
    input logic       idex_bubble,
    input logic       if_flush
);

    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R2: a writer that entered execute last cycle blocks a matching reader
    a_r2_ex_raw: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1) && !ex_taken &&
        $past(id_valid && id_we && (id_rd != 5'd0) && !idex_bubble) &&
        id_valid && id_rs1_used && (id_rs1 == $past(id_rd))
        |-> idex_bubble);

    // R5: a memory access issued two cycles ago owns the port now
    a_r5_port_busy: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) && !ex_taken &&
        $past(id_valid && id_mem && !idex_bubble, 2)
        |-> pc_hold);

    // R6: a data hold is a single consistent hold, never a flush
    a_r6_one_hold: assert property (@(posedge clk) disable iff (rst)
        ifid_hold |-> (pc_hold && idex_bubble && !if_flush));

    // R7: a branch leaving decode squashes the slot behind it
    a_r7_branch_squash: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_branch && !idex_bubble) |-> (pc_hold && if_flush));

    // R8: a taken branch in execute flushes fetch
    a_r8_taken_flush: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd1) && ex_taken &&
        $past(id_valid && id_branch && !idex_bubble)
        |-> (if_flush && !ifid_hold));

endmodule

bind stall_ctrl stall_ctrl_chk chk (.*);

// File: tb/stall_ctrl_test.sv
`timescale 1ns/1ps
module stall_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       id_valid, id_rs1_used, id_rs2_used, id_we, id_mem, id_branch, ex_taken;
    logic [4:0] id_rs1, id_rs2, id_rd;
    logic       pc_hold, ifid_hold, idex_bubble, if_flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    stall_ctrl uut (
        .clk(clk), .rst(rst),
        .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
        .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .id_rd(id_rd), .id_we(id_we), .id_mem(id_mem), .id_branch(id_branch),
        .ex_taken(ex_taken),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .if_flush(if_flush)
    );

    // Output vector order: {pc_hold, ifid_hold, idex_bubble, if_flush}
    task automatic compare(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {pc_hold, ifid_hold, idex_bubble, if_flush};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
    endtask

    // Driver: applies one decode instruction after the edge, queues the expectation
    task automatic step(input logic v,
                        input logic [4:0] s1, input logic u1,
                        input logic [4:0] s2, input logic u2,
                        input logic [4:0] rd, input logic we,
                        input logic mem, input logic br, input logic tk,
                        input logic [3:0] exp, input string tag);
        @(posedge clk);
        #1;
        id_valid = v; id_rs1 = s1; id_rs1_used = u1; id_rs2 = s2; id_rs2_used = u2;
        id_rd = rd; id_we = we; id_mem = mem; id_branch = br; ex_taken = tk;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic nop(input logic tk, input logic [3:0] exp, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, tk, exp, tag);
    endtask

    // Monitor: compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: outputs stuck expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        id_valid = 0; id_rs1 = 0; id_rs1_used = 0; id_rs2 = 0; id_rs2_used = 0;
        id_rd = 0; id_we = 0; id_mem = 0; id_branch = 0; ex_taken = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(4'b0000, "R1 during reset");
        @(posedge clk);
        #1 rst = 1'b0;

        nop(0, 4'b0000, "R1 idle after reset");
        // read after write, producer directly ahead
        step(1, 2, 1, 3, 1, 1, 1, 0, 0, 0, 4'b0000, "R2 producer issues");
        step(1, 1, 1, 5, 1, 4, 1, 0, 0, 0, 4'b1110, "R2 producer in EX");
        step(1, 1, 1, 5, 1, 4, 1, 0, 0, 0, 4'b1110, "R2 producer in MEM");
        step(1, 1, 1, 5, 1, 4, 1, 0, 0, 0, 4'b0000, "R3 producer in WB");
        nop(0, 4'b0000, "R3 drain");
        // ignored dependencies
        step(1, 7, 1, 8, 1, 0, 1, 0, 0, 0, 4'b0000, "R4 writer of r0");
        step(1, 0, 1, 9, 1, 6, 0, 0, 0, 0, 4'b0000, "R4 reads r0");
        step(1, 6, 1, 9, 1, 0, 0, 0, 0, 0, 4'b0000, "R4 write enable low");
        step(1, 11, 1, 11, 1, 10, 1, 0, 0, 0, 4'b0000, "R4 writer of r10");
        step(1, 10, 0, 12, 1, 0, 0, 0, 0, 0, 4'b0000, "R4 unused source");
        nop(0, 4'b0000, "R4 drain");
        nop(0, 4'b0000, "R4 drain");
        // load followed by dependent
        step(1, 14, 1, 0, 0, 13, 1, 1, 0, 0, 4'b0000, "R3 load issues");
        step(1, 13, 1, 0, 1, 15, 1, 0, 0, 0, 4'b1110, "R3 load in EX");
        step(1, 13, 1, 0, 1, 15, 1, 0, 0, 0, 4'b1110, "R6 load in MEM combined hold");
        step(1, 13, 1, 0, 1, 15, 1, 0, 0, 0, 4'b0000, "R3 load in WB");
        // structural hazard alone
        step(1, 1, 1, 2, 1, 0, 0, 1, 0, 0, 4'b0000, "R5 store issues");
        nop(0, 4'b0000, "R5 store in EX");
        step(1, 17, 1, 18, 1, 16, 1, 0, 0, 0, 4'b1001, "R5 store in MEM");
        nop(0, 4'b0000, "R5 port free");
        // branches
        step(1, 20, 1, 21, 1, 0, 0, 0, 1, 0, 4'b1001, "R7 branch leaves ID");
        nop(1, 4'b0001, "R8 taken in EX");
        nop(1, 4'b0000, "R9 taken with empty EX");
        step(1, 22, 1, 22, 1, 0, 0, 0, 1, 0, 4'b1001, "R7 second branch");
        nop(0, 4'b0000, "R8 not taken");
        step(1, 24, 1, 25, 1, 23, 1, 0, 0, 0, 4'b0000, "R10 producer issues");
        step(1, 23, 1, 26, 1, 0, 0, 0, 1, 0, 4'b1110, "R10 branch stalled EX");
        step(1, 23, 1, 26, 1, 0, 0, 0, 1, 0, 4'b1110, "R10 branch stalled MEM");
        step(1, 23, 1, 26, 1, 0, 0, 0, 1, 0, 4'b1001, "R10 branch released");
        nop(1, 4'b0001, "R8 taken after stall");
        // taken and not taken with busy memory port
        step(1, 1, 1, 2, 1, 0, 0, 1, 0, 0, 4'b0000, "R8 store ahead of branch");
        step(1, 3, 1, 4, 1, 0, 0, 0, 1, 0, 4'b1001, "R7 branch behind store");
        nop(1, 4'b0001, "R8 taken wins over port");
        step(1, 1, 1, 2, 1, 0, 0, 1, 0, 0, 4'b0000, "R5 store ahead of branch");
        step(1, 3, 1, 4, 1, 0, 0, 0, 1, 0, 4'b1001, "R7 branch behind store");
        nop(0, 4'b1001, "R5 not taken with port busy");
        step(1, 5, 1, 6, 1, 7, 1, 0, 0, 0, 4'b0000, "R9 plain op issues");
        nop(1, 4'b0000, "R9 taken with non-branch EX");
        nop(0, 4'b0000, "R1 final idle");

        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule